// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block gathers interrupt requests from a set of peripheral source nodes and drives a single active-low interrupt line towards a processor. Every node carries a pending flag, an enable bit and a priority value. Among the nodes that are pending, enabled and of nonzero priority, the controller picks the one with the highest priority. That priority must be strictly above the level now in service. The controller then raises the interrupt line and presents the address of the winner's entry in a vector table. When the processor performs its vector fetch, the block clears the winner's pending flag and pushes the winner's priority onto a stack of active levels. An ISR-exit strobe pops that stack.

Software sets up the controller through a small word-addressed register bus. A standby enable input keeps the configuration and the level logic in reset while it is low. Pending flags are the exception: they keep capturing requests and stay open to software. If the request has gone away by the time of the fetch, the fetch returns the first table entry, which serves as the default vector.

Top module: `vic_top`

## Requirements
- R1: While `stby_en` is low, the control register, the vector base, every enable bit, every priority field and the level stack are held at zero and ignore writes, and `irq_n` is high in the same cycle that `stby_en` falls.
- R2: Pending flags are untouched by standby. A high `src_req[i]` sets pending i at the next edge. A write to node address 16+i loads wdata bit 0 into pending i. Both work whatever the state of `stby_en`.
- R3: A node is eligible only when its pending flag, its enable bit (node bit 1) and its priority (node bits 7:4) are all set or nonzero. A node with any one of these missing leaves `irq_n` high.
- R4: When control bits 0 and 1 (address 0) are both set and an eligible node has a priority above the active level, `irq_n` goes low at the second clock edge after the write that makes it eligible.
- R5: The node with the highest priority wins. Among nodes of equal priority, the lowest index wins.
- R6: `vec_addr` equals the base register plus 4 × (winner index + 1). The base register is at address 1 and keeps only wdata bits 31:9, and bits 8:0 read back as zero.
- R7: A `vec_fetch` cycle clears the winner's pending flag and releases `irq_n` at the next edge.
- R8: Once `irq_n` is low, clearing the control enables does not release it before the fetch. After the fetch, no new request is raised while the enables stay cleared.
- R9: A fetch with no eligible winner returns the base address (entry 0) and leaves the active level unchanged.
- R10: A fetch pushes the winner's priority as the active level, so that only a strictly higher priority can raise a nested request. Each `isr_exit` pulse returns to the level below.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stby_en | input | 1 | Unit enable; low holds configuration and levels in reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 5 | Word address: 0 control, 1 base, 16+i node i |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| src_req | input | 16 | Peripheral request lines, one per node |
| vec_fetch | input | 1 | Vector fetch strobe from the processor |
| vec_addr | output | 32 | Address of the vector table entry to fetch |
| isr_exit | input | 1 | End-of-service strobe |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The assertions rely on three assumptions about the inputs. An `isr_exit` pulse is sent only while a level is on the stack. A `vec_fetch` lasts exactly one cycle. A software write to a node never falls in the same cycle as a fetch. The bench keeps to these by pairing each exit with an earlier real fetch. It also drives every strobe for a single cycle on the falling edge, and it issues fetches only after its register writes have completed. Because priorities on the stack rise strictly, the push never finds the stack full.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned BASE_LSB = 9;

  typedef enum logic [1:0] {
    RSEL_CTRL = 2'd0,
    RSEL_BASE = 2'd1,
    RSEL_NODE = 2'd2,
    RSEL_NONE = 2'd3
  } rsel_e;
endpackage

// File: rtl/vic_src_node.sv
module vic_src_node #(
  parameter int unsigned PRIO_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stby_en,
  input  logic              wr,
  input  logic              wr_pend,
  input  logic              wr_en,
  input  logic [PRIO_W-1:0] wr_prio,
  input  logic              src_req,
  input  logic              fetch_clr,
  output logic              pend_o,
  output logic              en_o,
  output logic [PRIO_W-1:0] prio_o,
  output logic              elig_o
);
  logic              pend_q, pend_d;
  logic              en_q, en_d;
  logic [PRIO_W-1:0] prio_q, prio_d;

  always_comb begin
    pend_d = pend_q;
    if (wr)             pend_d = wr_pend;
    else if (fetch_clr) pend_d = 1'b0;
    if (src_req)        pend_d = 1'b1;
  end

  always_comb begin
    en_d   = en_q;
    prio_d = prio_q;
    if (!stby_en) begin
      en_d   = 1'b0;
      prio_d = '0;
    end else if (wr) begin
      en_d   = wr_en;
      prio_d = wr_prio;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      en_q   <= 1'b0;
      prio_q <= '0;
    end else begin
      pend_q <= pend_d;
      en_q   <= en_d;
      prio_q <= prio_d;
    end
  end

  assign pend_o = pend_q;
  assign en_o   = en_q;
  assign prio_o = prio_q;
  assign elig_o = pend_q && en_q && (prio_q != '0);

  assert_cfg_held_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !stby_en |=> (!en_q && prio_q == '0));

  assert_fetch_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_clr && !src_req && !wr) |=> !pend_q);

  assert_req_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    src_req |=> pend_q);
endmodule

// File: rtl/vic_arbiter.sv
module vic_arbiter #(
  parameter int unsigned NSRC   = 16,
  parameter int unsigned PRIO_W = 4,
  localparam int unsigned IDX_W = $clog2(NSRC)
) (
  input  logic [NSRC-1:0]        elig,
  input  logic [NSRC*PRIO_W-1:0] prio_flat,
  input  logic [PRIO_W-1:0]      level,
  output logic                   win_vld,
  output logic [IDX_W-1:0]       win_idx,
  output logic [PRIO_W-1:0]      win_prio
);
  always_comb begin
    win_vld  = 1'b0;
    win_idx  = '0;
    win_prio = level;
    for (int i = 0; i < NSRC; i++) begin
      if (elig[i] && prio_flat[i*PRIO_W +: PRIO_W] > win_prio) begin
        win_vld  = 1'b1;
        win_idx  = IDX_W'(i);
        win_prio = prio_flat[i*PRIO_W +: PRIO_W];
      end
    end
  end
endmodule

// File: rtl/vic_lvl_stack.sv
module vic_lvl_stack #(
  parameter int unsigned DEPTH  = 15,
  parameter int unsigned PRIO_W = 4,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              push,
  input  logic [PRIO_W-1:0] push_lvl,
  input  logic              pop,
  output logic [PRIO_W-1:0] level_o,
  output logic              full_o,
  output logic              empty_o
);
  logic [PRIO_W-1:0] ent_q [DEPTH];
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              wr_ent;
  logic [CNT_W-1:0]  wr_ptr;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign level_o = empty_o ? '0 : ent_q[cnt_q - 1'b1];

  always_comb begin
    cnt_d  = cnt_q;
    wr_ent = 1'b0;
    wr_ptr = cnt_q;
    if (flush) begin
      cnt_d = '0;
    end else if (push && pop && !empty_o) begin
      wr_ent = 1'b1;
      wr_ptr = cnt_q - 1'b1;
    end else if (push && !full_o) begin
      wr_ent = 1'b1;
      cnt_d  = cnt_q + 1'b1;
    end else if (pop && !empty_o) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                 ent_q[g] <= '0;
      else if (wr_ent && wr_ptr == CNT_W'(g))     ent_q[g] <= push_lvl;
    end
  end

  assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !flush && !pop) |-> !full_o);

  assert_flush_empties_R1: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> empty_o);
endmodule

// File: rtl/vic_top.sv
module vic_top #(
  parameter int unsigned NSRC   = 16,
  parameter int unsigned PRIO_W = 4,
  parameter int unsigned DEPTH  = 15,
  localparam int unsigned IDX_W  = $clog2(NSRC),
  localparam int unsigned ADDR_W = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stby_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [NSRC-1:0]   src_req,
  input  logic              vec_fetch,
  output logic [31:0]       vec_addr,
  input  logic              isr_exit,
  output logic              irq_n
);
  import vic_pkg::*;

  logic                     glb_en_q, glb_en_d;
  logic                     cpu_en_q, cpu_en_d;
  logic [31:BASE_LSB]       base_q, base_d;
  logic                     irq_q, irq_d;
  logic [NSRC-1:0]          node_wr, elig, pend, en, clr_vec;
  logic [NSRC*PRIO_W-1:0]   prio_flat;
  logic                     win_vld;
  logic [IDX_W-1:0]         win_idx;
  logic [PRIO_W-1:0]        win_prio, act_lvl;
  logic                     stk_full, stk_empty;
  logic                     take;
  logic [IDX_W:0]           slot;
  rsel_e                    rsel;
  logic [IDX_W-1:0]         node_sel;
  logic                     unused_wdata;

  assign unused_wdata = ^{bus_wdata[8], bus_wdata[3:2]};
  assign node_sel     = bus_addr[IDX_W-1:0];

  always_comb begin
    if (bus_addr[ADDR_W-1])
      rsel = (int'(node_sel) < NSRC) ? RSEL_NODE : RSEL_NONE;
    else if (bus_addr == ADDR_W'(0)) rsel = RSEL_CTRL;
    else if (bus_addr == ADDR_W'(1)) rsel = RSEL_BASE;
    else                             rsel = RSEL_NONE;
  end

  always_comb begin
    glb_en_d = glb_en_q;
    cpu_en_d = cpu_en_q;
    base_d   = base_q;
    if (!stby_en) begin
      glb_en_d = 1'b0;
      cpu_en_d = 1'b0;
      base_d   = '0;
    end else if (bus_we && rsel == RSEL_CTRL) begin
      glb_en_d = bus_wdata[0];
      cpu_en_d = bus_wdata[1];
    end else if (bus_we && rsel == RSEL_BASE) begin
      base_d = bus_wdata[31:BASE_LSB];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      glb_en_q <= 1'b0;
      cpu_en_q <= 1'b0;
      base_q   <= '0;
    end else begin
      glb_en_q <= glb_en_d;
      cpu_en_q <= cpu_en_d;
      base_q   <= base_d;
    end
  end

  assign take = vec_fetch && win_vld;

  for (genvar g = 0; g < NSRC; g++) begin : g_node
    assign node_wr[g] = bus_we && (rsel == RSEL_NODE) && (node_sel == IDX_W'(g));
    assign clr_vec[g] = take && (win_idx == IDX_W'(g));
    vic_src_node #(.PRIO_W(PRIO_W)) u_node (
      .clk      (clk),
      .rst_n    (rst_n),
      .stby_en  (stby_en),
      .wr       (node_wr[g]),
      .wr_pend  (bus_wdata[0]),
      .wr_en    (bus_wdata[1]),
      .wr_prio  (bus_wdata[4 +: PRIO_W]),
      .src_req  (src_req[g]),
      .fetch_clr(clr_vec[g]),
      .pend_o   (pend[g]),
      .en_o     (en[g]),
      .prio_o   (prio_flat[g*PRIO_W +: PRIO_W]),
      .elig_o   (elig[g])
    );
  end

  vic_arbiter #(.NSRC(NSRC), .PRIO_W(PRIO_W)) u_arb (
    .elig     (elig),
    .prio_flat(prio_flat),
    .level    (act_lvl),
    .win_vld  (win_vld),
    .win_idx  (win_idx),
    .win_prio (win_prio)
  );

  vic_lvl_stack #(.DEPTH(DEPTH), .PRIO_W(PRIO_W)) u_stk (
    .clk     (clk),
    .rst_n   (rst_n),
    .flush   (!stby_en),
    .push    (take),
    .push_lvl(win_prio),
    .pop     (isr_exit),
    .level_o (act_lvl),
    .full_o  (stk_full),
    .empty_o (stk_empty)
  );

  always_comb begin
    irq_d = irq_q;
    if (!stby_en)      irq_d = 1'b0;
    else if (vec_fetch) irq_d = 1'b0;
    else if (glb_en_q && cpu_en_q && win_vld) irq_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  assign irq_n = !(irq_q && stby_en);

  assign slot     = win_vld ? ({1'b0, win_idx} + (IDX_W+1)'(1)) : '0;
  assign vec_addr = {base_q, {BASE_LSB{1'b0}}}
                  + {{(32-IDX_W-3){1'b0}}, slot, 2'b00};

  always_comb begin
    bus_rdata = '0;
    case (rsel)
      RSEL_CTRL: bus_rdata = {30'b0, cpu_en_q, glb_en_q};
      RSEL_BASE: bus_rdata = {base_q, {BASE_LSB{1'b0}}};
      RSEL_NODE: bus_rdata = 32'({prio_flat[node_sel*PRIO_W +: PRIO_W], 2'b00,
                                  en[node_sel], pend[node_sel]});
      default:   bus_rdata = '0;
    endcase
  end

  assert_irq_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_q && !vec_fetch && stby_en) |=> irq_q);

  assert_one_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(clr_vec));

  assert_push_level_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (take && stby_en && !isr_exit && !stk_full) |=> (act_lvl == $past(win_prio)));

  assert_spurious_keeps_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_fetch && !win_vld && !isr_exit && stby_en) |=> $stable(act_lvl));

  assert_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    vec_fetch |=> irq_n);
endmodule

// File: tb/tb_vic_top.sv
module tb_vic_top;
  localparam int unsigned NSRC = 16;

  logic        clk;
  logic        rst_n;
  logic        stby_en;
  logic        bus_we;
  logic [4:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [NSRC-1:0] src_req;
  logic        vec_fetch;
  logic [31:0] vec_addr;
  logic        isr_exit;
  logic        irq_n;

  int compared;
  int mismatched;

  localparam logic [31:0] BASE = 32'h1234_5600;

  vic_top dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .stby_en  (stby_en),
    .bus_we   (bus_we),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .src_req  (src_req),
    .vec_fetch(vec_fetch),
    .vec_addr (vec_addr),
    .isr_exit (isr_exit),
    .irq_n    (irq_n)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic node(input int i, input logic p, input logic e, input logic [3:0] pr);
    wr(5'(16 + i), {24'b0, pr, 2'b00, e, p});
  endtask

  task automatic fetch(output logic [31:0] va);
    vec_fetch = 1'b1;
    #1;
    va = vec_addr;
    @(negedge clk);
    vec_fetch = 1'b0;
  endtask

  task automatic leave();
    isr_exit = 1'b1;
    @(negedge clk);
    isr_exit = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 irq_n after reset", 32'(irq_n), 32'd1);
    rd(5'd0, d); chk("R1 ctrl after reset", d, 32'd0);
    rd(5'd1, d); chk("R6 base after reset", d, 32'd0);
  endtask

  task automatic t_standby_regs();
    logic [31:0] d;
    stby_en = 1'b0;
    @(negedge clk);
    wr(5'd0, 32'h3);
    rd(5'd0, d); chk("R1 ctrl write ignored in standby", d, 32'd0);
    node(2, 1'b1, 1'b1, 4'd5);
    rd(5'd18, d); chk("R2 sw set pending in standby, R1 cfg held", d, 32'h1);
    src_req[0] = 1'b1;
    @(negedge clk);
    src_req[0] = 1'b0;
    rd(5'd16, d); chk("R2 src_req sets pending in standby", d, 32'h1);
    node(0, 1'b0, 1'b0, 4'd0);
    node(2, 1'b0, 1'b0, 4'd0);
    rd(5'd16, d); chk("R2 sw clear pending", d, 32'h0);
    stby_en = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_eligible();
    logic [31:0] d, va;
    wr(5'd1, 32'h1234_5678);
    rd(5'd1, d); chk("R6 base keeps bits 31:9", d, BASE);
    wr(5'd0, 32'h3);
    node(3, 1'b1, 1'b0, 4'd5);
    @(negedge clk);
    chk("R3 disabled pending node ignored", 32'(irq_n), 32'd1);
    node(3, 1'b1, 1'b1, 4'd0);
    @(negedge clk);
    chk("R3 zero priority node ignored", 32'(irq_n), 32'd1);
    node(3, 1'b1, 1'b1, 4'd5);
    chk("R4 irq_n not yet low one edge after write", 32'(irq_n), 32'd1);
    @(negedge clk);
    chk("R4 irq_n low two edges after write", 32'(irq_n), 32'd0);
    fetch(va);
    chk("R6 vector of node 3", va, BASE + 32'h10);
    chk("R7 irq_n released after fetch", 32'(irq_n), 32'd1);
    rd(5'd19, d); chk("R7 pending cleared by fetch", d, 32'h52);
    leave();
    node(3, 1'b0, 1'b0, 4'd0);
  endtask

  task automatic t_priority();
    logic [31:0] va;
    node(4, 1'b1, 1'b1, 4'd3);
    node(2, 1'b1, 1'b1, 4'd7);
    node(9, 1'b1, 1'b1, 4'd7);
    @(negedge clk);
    fetch(va);
    chk("R5 highest priority, lowest index tie", va, BASE + 32'd12);
    @(negedge clk);
    @(negedge clk);
    chk("R10 equal or lower priority blocked while nested", 32'(irq_n), 32'd1);
    node(11, 1'b1, 1'b1, 4'd9);
    @(negedge clk);
    chk("R10 higher priority nests", 32'(irq_n), 32'd0);
    fetch(va);
    chk("R6 vector of node 11", va, BASE + 32'd48);
    leave();
    @(negedge clk);
    chk("R10 exit to level 7 keeps tie blocked", 32'(irq_n), 32'd1);
    leave();
    @(negedge clk);
    chk("R10 exit to level 0 lets node 9 in", 32'(irq_n), 32'd0);
    fetch(va);
    chk("R5 node 9 served next", va, BASE + 32'd40);
    leave();
    @(negedge clk);
    fetch(va);
    chk("R5 lowest priority served last", va, BASE + 32'd20);
    leave();
    node(2, 1'b0, 1'b0, 4'd0);
    node(4, 1'b0, 1'b0, 4'd0);
    node(9, 1'b0, 1'b0, 4'd0);
    node(11, 1'b0, 1'b0, 4'd0);
  endtask

  task automatic t_global_hold();
    logic [31:0] va;
    node(5, 1'b1, 1'b1, 4'd4);
    @(negedge clk);
    chk("R4 irq_n low for node 5", 32'(irq_n), 32'd0);
    wr(5'd0, 32'h0);
    @(negedge clk);
    chk("R8 irq_n stays low after enables cleared", 32'(irq_n), 32'd0);
    fetch(va);
    chk("R8 held request still vectored", va, BASE + 32'd24);
    node(6, 1'b1, 1'b1, 4'd8);
    @(negedge clk);
    @(negedge clk);
    chk("R8 new request blocked while disabled", 32'(irq_n), 32'd1);
    leave();
    node(6, 1'b0, 1'b0, 4'd0);
    node(5, 1'b0, 1'b0, 4'd0);
    wr(5'd0, 32'h3);
  endtask

  task automatic t_spurious();
    logic [31:0] va;
    node(7, 1'b1, 1'b1, 4'd2);
    @(negedge clk);
    chk("R4 irq_n low for node 7", 32'(irq_n), 32'd0);
    node(7, 1'b0, 1'b1, 4'd2);
    fetch(va);
    chk("R9 vanished request returns default entry", va, BASE);
    node(8, 1'b1, 1'b1, 4'd1);
    @(negedge clk);
    chk("R9 level unchanged after spurious fetch", 32'(irq_n), 32'd0);
    fetch(va);
    chk("R6 vector of node 8", va, BASE + 32'd36);
    leave();
    node(7, 1'b0, 1'b0, 4'd0);
    node(8, 1'b0, 1'b0, 4'd0);
  endtask

  task automatic t_standby_irq();
    logic [31:0] d;
    node(1, 1'b1, 1'b1, 4'd6);
    @(negedge clk);
    chk("R4 irq_n low for node 1", 32'(irq_n), 32'd0);
    stby_en = 1'b0;
    #1;
    chk("R1 irq_n released at once by standby", 32'(irq_n), 32'd1);
    @(negedge clk);
    rd(5'd0, d);  chk("R1 ctrl cleared by standby", d, 32'd0);
    rd(5'd17, d); chk("R2 pending survives standby, R1 cfg cleared", d, 32'h1);
    rd(5'd1, d);  chk("R1 base cleared by standby", d, 32'd0);
    stby_en = 1'b1;
    node(1, 1'b0, 1'b0, 4'd0);
  endtask

  initial begin
    compared = 0; mismatched = 0;
    rst_n = 1'b0; stby_en = 1'b1; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    src_req = '0; vec_fetch = 1'b0; isr_exit = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_standby_regs();
    t_eligible();
    t_priority();
    t_global_hold();
    t_spurious();
    t_standby_irq();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #1_000_000;
    compared++;
    mismatched++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule